// File: doc/BRIEF.md
# Audio Frame Step Sequencer

This block paces the slow-rate housekeeping of a retro console sound unit. It counts internal audio clocks and, at fixed positions in a repeating frame, emits a one-clock quarter-frame pulse and a one-clock half-frame pulse. Downstream channel logic uses the quarter pulse to clock linear counters and the half pulse to clock length counters. In the four-step mode the sequencer also raises a frame interrupt flag near the end of every frame.

Software selects the mode with a control write: bit 7 picks the step pattern and bit 6 inhibits the interrupt. A write is accepted only on an even internal clock, and each accepted write restarts the frame. A status read strobe clears the interrupt flag. Coming out of reset, the sequencer behaves as if a control write of 0x00 had been accepted a fixed number of clocks earlier.

Cycle numbering used below: the clock period that follows the edge accepting a control write is cycle 0 of the new frame. Cycle n is the n-th period after that one.

Top module: `frame_sequencer`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, all four outputs are 0. The sequencer starts in the four-step mode with the interrupt enabled, as though a write of 0x00 had been accepted `RESET_OFFSET` (default 10) clocks earlier. With the default, the first quarter pulse falls in cycle 7449, counting the first cycle after release as cycle 0.
- R2: Bit 7 of `ctrlData` selects the mode. 0 selects the four-step mode and 1 selects the five-step mode. Bit 6 is the interrupt inhibit. The other bits are ignored.
- R3: In the four-step mode, quarter pulses fall in cycles 7459, 14915, 22373 and 29831. Half pulses fall in cycles 14915 and 29831 only. No pulse occurs in any other cycle up to 29832.
- R4: In the four-step mode, with the inhibit clear, the flag is set by the steps at cycles 29830, 29831 and 29832, so `irqFlag` reads 1 from cycle 29831. A status read in a cycle that also sets the flag does not clear it.
- R5: The four-step frame repeats every 29830 clocks. The next quarter pulse after cycle 29831 falls in cycle 37289.
- R6: In the five-step mode, quarter and half pulses fall together in cycles 1 and 14915. A quarter pulse alone falls in cycles 7459 and 22373. Nothing happens at cycle 29829. The frame repeats every 37282 clocks, so the next joint pulse falls in cycle 37283.
- R7: The five-step mode never sets the interrupt flag.
- R8: A write with `evenPhase` high at the clock edge is accepted at that edge. A write with `evenPhase` low is accepted at the next edge, which delays every step by one clock.
- R9: Once set, the flag stays 1. It is cleared only by a status read in a cycle with no set request, and then reads 0 from the next cycle. It is also cleared by an accepted control write with bit 6 set, and this clear takes priority over a set. A control write with bit 6 clear leaves the flag unchanged.
- R10: While the inhibit is 1 the flag is never set. `irqOut` equals `irqFlag` AND NOT inhibit.
- R11: Quarter and half pulses are one clock wide and never occur in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal audio clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrite | input | 1 | Control register write strobe |
| ctrlData | input | 8 | Control write data: bit 7 mode, bit 6 interrupt inhibit |
| statusRead | input | 1 | Status register read strobe; clears the flag |
| evenPhase | input | 1 | High when the coming clock edge is an even internal clock |
| quarterPulse | output | 1 | Quarter-frame pulse (linear counter clock) |
| halfPulse | output | 1 | Half-frame pulse (length counter clock) |
| irqFlag | output | 1 | Frame interrupt flag |
| irqOut | output | 1 | Interrupt request line |

## Verification
The step schedule is checked in both modes, on the cycle just before each step, on the step itself and on the cycle after it. This separates an off-by-one compare or a stretched pulse from a correct one. Checks also cross the wrap point of each mode, which separates the four-step period of 29830 from the five-step period of 37282 and shows whether the counter restarts at the right value.

The flag is probed with a status read that lands on a set cycle and with another that lands just after the window. It is also probed across control writes with and without bit 6 set, which tells set-over-read priority apart from plain clearing. Writes placed on odd and even phases show the one-clock acceptance delay. The inhibited run shows that the flag and `irqOut` stay low while the pulses carry on unchanged.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic {
    MODE_FOUR = 1'b0,
    MODE_FIVE = 1'b1
  } seqMode_t;

  // strobes from control to the step counter
  typedef struct packed {
    logic restart;    // accepted control write: frame begins at 0
    logic wrapShort;  // end of four-step frame
    logic wrapLong;   // end of five-step frame
  } seqCmd_t;

endpackage

// File: rtl/frame_seq_count.sv
module frame_seq_count
  import frame_seq_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int RESET_OFFSET  = 10,
  parameter int SHORT_RESTART = 3,
  parameter int LONG_RESTART  = 1,
  parameter int LONG_END      = 37282
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCmd_t          cmd,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] RST_VAL   = CNT_W'(RESET_OFFSET);
  localparam logic [CNT_W-1:0] SHORT_VAL = CNT_W'(SHORT_RESTART);
  localparam logic [CNT_W-1:0] LONG_VAL  = CNT_W'(LONG_RESTART);
  localparam logic [CNT_W-1:0] LONG_MAX  = CNT_W'(LONG_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= RST_VAL;
    end else if (cmd.restart) begin
      count <= '0;
    end else if (cmd.wrapShort) begin
      count <= SHORT_VAL;
    end else if (cmd.wrapLong) begin
      count <= LONG_VAL;
    end else begin
      count <= count + 1'b1;
    end
  end

  // R5 / R6: the frame position never runs past the longest frame
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= LONG_MAX);

endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STEP1    = 7459,
  parameter int STEP2    = 14915,
  parameter int STEP3    = 22373,
  parameter int STEP4    = 29829,
  parameter int LONG_END = 37282
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrite,
  input  logic [7:0]       ctrlData,
  input  logic             statusRead,
  input  logic             evenPhase,
  input  logic [CNT_W-1:0] count,
  output seqCmd_t          cmd,
  output logic             quarterPulse,
  output logic             halfPulse,
  output logic             irqFlag,
  output logic             irqOut
);

  localparam logic [CNT_W-1:0] C_ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_S1      = CNT_W'(STEP1);
  localparam logic [CNT_W-1:0] C_S2      = CNT_W'(STEP2);
  localparam logic [CNT_W-1:0] C_S3      = CNT_W'(STEP3);
  localparam logic [CNT_W-1:0] C_IRQ_LO  = CNT_W'(STEP4 + 1);
  localparam logic [CNT_W-1:0] C_LAST4   = CNT_W'(STEP4 + 2);
  localparam logic [CNT_W-1:0] C_IRQ_HI  = CNT_W'(STEP4 + 3);
  localparam logic [CNT_W-1:0] C_END5    = CNT_W'(LONG_END);

  seqMode_t mode;
  logic     inhibit;
  logic     pendValid;
  logic [1:0] pendBits;     // {mode, inhibit} of a write held over an odd clock
  logic       acceptNow;
  logic [1:0] acceptBits;
  logic       setReq;
  logic       clearByWrite;
  logic       unusedCtrlBits;

  assign unusedCtrlBits = ^ctrlData[5:0];

  // write acceptance: only on even clocks; an odd write waits one clock
  assign acceptNow  = evenPhase && (ctrlWrite || pendValid);
  assign acceptBits = ctrlWrite ? ctrlData[7:6] : pendBits;
  assign clearByWrite = acceptNow && acceptBits[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendBits  <= '0;
      mode      <= MODE_FOUR;
      inhibit   <= 1'b0;
    end else begin
      if (ctrlWrite && !evenPhase) begin
        pendValid <= 1'b1;
        pendBits  <= ctrlData[7:6];
      end else if (evenPhase) begin
        pendValid <= 1'b0;
      end
      if (acceptNow) begin
        mode    <= seqMode_t'(acceptBits[1]);
        inhibit <= acceptBits[0];
      end
    end
  end

  // step decode
  always_comb begin
    quarterPulse = 1'b0;
    halfPulse    = 1'b0;
    setReq       = 1'b0;
    if (mode == MODE_FOUR) begin
      quarterPulse = (count == C_S1) || (count == C_S2) ||
                     (count == C_S3) || (count == C_LAST4);
      halfPulse    = (count == C_S2) || (count == C_LAST4);
      setReq       = !inhibit && (count >= C_IRQ_LO) && (count <= C_IRQ_HI);
    end else begin
      quarterPulse = (count == C_ONE) || (count == C_S1) ||
                     (count == C_S2) || (count == C_S3);
      halfPulse    = (count == C_ONE) || (count == C_S2);
    end
  end

  always_comb begin
    cmd.restart   = acceptNow;
    cmd.wrapShort = (mode == MODE_FOUR) && (count == C_IRQ_HI);
    cmd.wrapLong  = (mode == MODE_FIVE) && (count == C_END5);
  end

  // frame interrupt flag: write-clear beats set, set beats read-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (clearByWrite) begin
      irqFlag <= 1'b0;
    end else if (setReq) begin
      irqFlag <= 1'b1;
    end else if (statusRead) begin
      irqFlag <= 1'b0;
    end
  end

  assign irqOut = irqFlag && !inhibit;

  // R11: pulses are one clock wide
  a_r11_quarter_single: assert property (@(posedge clk) disable iff (!rstN)
    quarterPulse |=> !quarterPulse);

  // R3 / R6: every half pulse coincides with a quarter pulse
  a_r3_half_with_quarter: assert property (@(posedge clk) disable iff (!rstN)
    halfPulse |-> quarterPulse);

  // R7 / R10: the flag rises only from the four-step mode with inhibit clear
  a_r7_rise_four_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> ($past(mode) == MODE_FOUR) && !$past(inhibit));

  // R9: without a clearing event the flag holds
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !statusRead && !clearByWrite) |=> irqFlag);

  // R8: a held write is consumed at the very next edge
  a_r8_pending_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |=> !pendValid);

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import frame_seq_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int STEP1        = 7459,
  parameter int STEP2        = 14915,
  parameter int STEP3        = 22373,
  parameter int STEP4        = 29829,
  parameter int LONG_END     = 37282,
  parameter int RESET_OFFSET = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrite,
  input  logic [7:0] ctrlData,
  input  logic       statusRead,
  input  logic       evenPhase,
  output logic       quarterPulse,
  output logic       halfPulse,
  output logic       irqFlag,
  output logic       irqOut
);

  // four-step frame: period is one past the silent step position
  localparam int SHORT_PERIOD  = STEP4 + 1;
  localparam int SHORT_LAST    = STEP4 + 3;
  localparam int SHORT_RESTART = SHORT_LAST + 1 - SHORT_PERIOD;
  localparam int LONG_RESTART  = 1;

  seqCmd_t          cmd;
  logic [CNT_W-1:0] count;

  frame_seq_ctrl #(
    .CNT_W(CNT_W), .STEP1(STEP1), .STEP2(STEP2), .STEP3(STEP3),
    .STEP4(STEP4), .LONG_END(LONG_END)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .ctrlData(ctrlData),
    .statusRead(statusRead), .evenPhase(evenPhase), .count(count),
    .cmd(cmd), .quarterPulse(quarterPulse), .halfPulse(halfPulse),
    .irqFlag(irqFlag), .irqOut(irqOut)
  );

  frame_seq_count #(
    .CNT_W(CNT_W), .RESET_OFFSET(RESET_OFFSET),
    .SHORT_RESTART(SHORT_RESTART), .LONG_RESTART(LONG_RESTART),
    .LONG_END(LONG_END)
  ) u_count (
    .clk(clk), .rstN(rstN), .cmd(cmd), .count(count)
  );

endmodule

// File: tb/test_frame_sequencer.sv
`timescale 1ns/1ps
module test_frame_sequencer;

  localparam int RST_OFS  = 10;
  localparam int WATCHDOG = 190000;
  localparam logic [1:0] K_CHK = 2'd0;
  localparam logic [1:0] K_WR  = 2'd1;
  localparam logic [1:0] K_RD  = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  data;
    logic [15:0] at;
    logic [3:0]  exp;   // {quarter, half, flag, irqOut}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    '{K_WR , 8'h00, 16'd0    , 4'b0000, 4'd2 },  // R2 four-step
    '{K_CHK, 8'h00, 16'd0    , 4'b0000, 4'd3 },  // R3
    '{K_CHK, 8'h00, 16'd1    , 4'b0000, 4'd3 },
    '{K_CHK, 8'h00, 16'd7458 , 4'b0000, 4'd3 },
    '{K_CHK, 8'h00, 16'd7459 , 4'b1000, 4'd3 },
    '{K_CHK, 8'h00, 16'd7460 , 4'b0000, 4'd11},  // R11
    '{K_CHK, 8'h00, 16'd14914, 4'b0000, 4'd3 },
    '{K_CHK, 8'h00, 16'd14915, 4'b1100, 4'd3 },
    '{K_CHK, 8'h00, 16'd22373, 4'b1000, 4'd3 },
    '{K_CHK, 8'h00, 16'd29829, 4'b0000, 4'd3 },
    '{K_CHK, 8'h00, 16'd29830, 4'b0000, 4'd4 },  // R4
    '{K_CHK, 8'h00, 16'd29831, 4'b1111, 4'd4 },
    '{K_RD , 8'h00, 16'd29831, 4'b0000, 4'd4 },  // read on a set cycle
    '{K_CHK, 8'h00, 16'd29832, 4'b0011, 4'd4 },
    '{K_CHK, 8'h00, 16'd29833, 4'b0011, 4'd4 },
    '{K_CHK, 8'h00, 16'd29834, 4'b0011, 4'd9 },  // R9 holds
    '{K_RD , 8'h00, 16'd29835, 4'b0000, 4'd9 },
    '{K_CHK, 8'h00, 16'd29836, 4'b0000, 4'd9 },
    '{K_CHK, 8'h00, 16'd37289, 4'b1000, 4'd5 },  // R5
    '{K_WR , 8'h80, 16'd0    , 4'b0000, 4'd2 },  // R2 five-step
    '{K_CHK, 8'h00, 16'd0    , 4'b0000, 4'd6 },  // R6
    '{K_CHK, 8'h00, 16'd1    , 4'b1100, 4'd6 },
    '{K_CHK, 8'h00, 16'd2    , 4'b0000, 4'd11},
    '{K_CHK, 8'h00, 16'd7459 , 4'b1000, 4'd6 },
    '{K_CHK, 8'h00, 16'd14915, 4'b1100, 4'd6 },
    '{K_CHK, 8'h00, 16'd22373, 4'b1000, 4'd6 },
    '{K_CHK, 8'h00, 16'd29829, 4'b0000, 4'd6 },
    '{K_CHK, 8'h00, 16'd29831, 4'b0000, 4'd7 },  // R7
    '{K_CHK, 8'h00, 16'd29833, 4'b0000, 4'd7 },
    '{K_CHK, 8'h00, 16'd37282, 4'b0000, 4'd6 },
    '{K_CHK, 8'h00, 16'd37283, 4'b1100, 4'd6 },
    '{K_WR , 8'h00, 16'd0    , 4'b0000, 4'd2 },
    '{K_CHK, 8'h00, 16'd29831, 4'b1111, 4'd4 },
    '{K_CHK, 8'h00, 16'd29833, 4'b0011, 4'd9 },
    '{K_WR , 8'h80, 16'd0    , 4'b0000, 4'd9 },  // bit 6 clear: flag kept
    '{K_CHK, 8'h00, 16'd0    , 4'b0011, 4'd9 },
    '{K_CHK, 8'h00, 16'd1    , 4'b1111, 4'd9 },
    '{K_WR , 8'hC0, 16'd0    , 4'b0000, 4'd9 },  // bit 6 set: flag cleared
    '{K_CHK, 8'h00, 16'd0    , 4'b0000, 4'd9 },
    '{K_CHK, 8'h00, 16'd1    , 4'b1100, 4'd6 },
    '{K_WR , 8'h40, 16'd0    , 4'b0000, 4'd10},  // R10 inhibited four-step
    '{K_CHK, 8'h00, 16'd29831, 4'b1100, 4'd10},
    '{K_CHK, 8'h00, 16'd29833, 4'b0000, 4'd10},
    '{K_CHK, 8'h00, 16'd37289, 4'b1000, 4'd5 }
  };

  logic       clk;
  logic       rstN;
  logic       ctrlWrite;
  logic [7:0] ctrlData;
  logic       statusRead;
  logic       evenPhase;
  logic       quarterPulse;
  logic       halfPulse;
  logic       irqFlag;
  logic       irqOut;

  int  tick;
  int  base;
  int  checks;
  int  failures;
  logic done;

  frame_sequencer i_frame_sequencer (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .ctrlData(ctrlData),
    .statusRead(statusRead), .evenPhase(evenPhase),
    .quarterPulse(quarterPulse), .halfPulse(halfPulse),
    .irqFlag(irqFlag), .irqOut(irqOut)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // advance to the next falling edge; phase applies to the coming rising edge
  task automatic step();
    @(negedge clk);
    tick = tick + 1;
    evenPhase = ~evenPhase;
  endtask

  task automatic waitRel(input int t);
    while (tick - base < t) step();
  endtask

  task automatic chk(input logic [3:0] exp, input int req, input string what);
    logic [3:0] got;
    got = {quarterPulse, halfPulse, irqFlag, irqOut};
    checks = checks + 1;
    if (got !== exp) begin
      failures = failures + 1;
      $display("FAIL R%0d %s cycle %0d: qhfi actual=%b expected=%b",
               req, what, tick - base, got, exp);
    end
  endtask

  task automatic ctrlWr(input logic [7:0] d, input logic onOdd);
    while (evenPhase != !onOdd) step();
    ctrlWrite = 1'b1;
    ctrlData  = d;
    step();
    ctrlWrite = 1'b0;
    ctrlData  = 8'h00;
    base = onOdd ? tick + 1 : tick;
  endtask

  task automatic readAt(input int t);
    waitRel(t);
    statusRead = 1'b1;
    step();
    statusRead = 1'b0;
  endtask

  initial begin
    done = 1'b0;
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick = 0; base = 0; checks = 0; failures = 0;
    rstN = 1'b0; ctrlWrite = 1'b0; ctrlData = 8'h00;
    statusRead = 1'b0; evenPhase = 1'b1;
    repeat (4) step();
    chk(4'b0000, 1, "in reset");                  // R1
    rstN = 1'b1;
    base = tick - RST_OFS;
    chk(4'b0000, 1, "first cycle after reset");   // R1
    waitRel(7458);
    chk(4'b0000, 1, "before first step");         // R1
    waitRel(7459);
    chk(4'b1000, 1, "first quarter after reset"); // R1

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].kind)
        K_WR:    ctrlWr(VECS[i].data, 1'b0);
        K_RD:    readAt(int'(VECS[i].at));
        default: begin
          waitRel(int'(VECS[i].at));
          chk(VECS[i].exp, int'(VECS[i].req), "table");
        end
      endcase
    end

    // R8: write on an odd clock is accepted one clock later
    ctrlWr(8'h00, 1'b1);
    waitRel(0);
    chk(4'b0000, 8, "odd write start");
    waitRel(7458);
    chk(4'b0000, 8, "odd write, no early step");
    waitRel(7459);
    chk(4'b1000, 8, "odd write, delayed step");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule